// File: doc/BRIEF.md
# Multi-Rail Power-On Reset Sequencer

This block turns a set of per-rail "supply above trip level" flags into one main reset and a user-mode flag. It watches a core rail, an analog rail and a parameterised number of configuration I/O-bank rails. Each flag has its own synchronizer, so each rail is detected independently. The main reset stays asserted until every rail reports good. A release delay then runs, and its length is set by a two-bit mode input: a long standard delay, a short fast delay, or an instant-on mode with no delay at all.

Once released, the block watches for brown-out. A drop on the core or analog rail asserts the main reset again and restarts the whole sequence. A drop on an I/O-bank rail is normally ignored. The exception is a release made in instant-on mode: for a limited window after that release, an I/O-bank drop also forces reset. All delays and the window are parameters counted in clock cycles. In simulation they are scaled down, so the window stands in for a few milliseconds of real time.

Top module: `por_sequencer`

## Requirements
- R1: While `rst_n` is low on a rising edge, `main_rst` becomes 1 and `user_mode` becomes 0. Both stay that way until all rails have been good long enough for a release.
- R2: Every rail flag passes through its own two-flop synchronizer. `main_rst` is released only when the core flag, the analog flag and every bit of `io_ok` are all high. If any one of them stays low, the block stays in reset.
- R3: When `delay_mode` is 2'b00 (standard), `main_rst` falls on the (3+STD_DLY)-th rising edge after the last rail flag rises. The value 2'b11 behaves the same as 2'b00.
- R4: When `delay_mode` is 2'b01 (fast), `main_rst` falls on the (3+FAST_DLY)-th rising edge after the last rail flag rises.
- R5: When `delay_mode` is 2'b10 (instant-on), `main_rst` falls on the 3rd rising edge after the last rail flag rises.
- R6: If any rail flag drops while the delay is counting, the count is abandoned. A full delay starts again from zero once all rails are good, and release comes 3+delay edges after the last rail recovers.
- R7: In user mode, a drop of the core flag or of the analog flag asserts `main_rst` on the 3rd rising edge after the drop. The release sequence then runs again.
- R8: After a release made in standard or fast mode, a drop on any `io_ok` bit leaves `main_rst` low and `user_mode` high.
- R9: After a release made in instant-on mode, an `io_ok` drop that reaches the sequencer within IO_WIN cycles of the release asserts `main_rst`.
- R10: After a release made in instant-on mode, an `io_ok` drop that comes later than IO_WIN cycles after the release is ignored.
- R11: `user_mode` is always the inverse of `main_rst`. Both are driven straight from flops.
- R12: `delay_mode` is sampled in the cycle in which the last rail is seen good. Changing it while the delay is counting does not alter the release time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_ok | input | 1 | Core rail above its trip level |
| analog_ok | input | 1 | Analog rail above its trip level |
| io_ok | input | N_IO | One flag per configuration I/O-bank rail |
| delay_mode | input | 2 | 00 standard, 01 fast, 10 instant-on, 11 standard |
| main_rst | output | 1 | Main reset, active high |
| user_mode | output | 1 | High when the main reset is released |

## Verification
The assertions check four things on every cycle: the two outputs stay complementary, a release only ever follows a cycle in which all synchronized rails were good, a core or analog drop in user mode always brings the reset back, and a drop during the countdown always returns the block to the hold state. They also check that an I/O drop outside an open instant-on window never resets the block, and that the two counters stay within their limits. Only the bench scenarios can show the exact release latency in each mode, the restart of the count after a drop, the frozen mode selection, and that an I/O drop lands on the correct side of the instant-on window.

// File: rtl/por_seq_pkg.sv
// Shared types for the power-on reset sequencer.
// Assumes: two-bit state and mode encodings are enough for all variants.
package por_seq_pkg;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,   // waiting for all rails
        ST_COUNT = 2'd1,   // release delay running
        ST_USER  = 2'd2    // main reset released
    } por_state_t;

    typedef enum logic [1:0] {
        DM_STD     = 2'b00,
        DM_FAST    = 2'b01,
        DM_INSTANT = 2'b10,
        DM_STD_ALT = 2'b11
    } dly_mode_t;

endpackage

// File: rtl/por_rail_sync.sv
// Two-flop synchronizer bank, one independent chain per rail flag.
// Assumes: a flag reads as "not good" while in reset.
module por_rail_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        for (genvar i = 0; i < W; i++) begin : g_chain
            logic s1, s2;

            // Two-stage resynchronisation of one rail flag.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s1 <= 1'b0;
                    s2 <= 1'b0;
                end else begin
                    s1 <= d[i];
                    s2 <= s1;
                end
            end

            assign q[i] = s2;
        end
    endgenerate

endmodule

// File: rtl/por_delay_timer.sv
// Release-delay counter. It clears while idle, counts while run is high,
// and flags done in the cycle whose count equals limit-1.
// Assumes: limit is at least 1 and is held steady while run is high.
module por_delay_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    input  logic [CW-1:0] limit,
    output logic          done
);

    logic [CW-1:0] cnt;

    // Count the elapsed cycles of the release delay.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt <= '0;
        else if (run)
            cnt <= cnt + 1'b1;
    end

    // Done in the final counted cycle.
    always_comb done = run && (cnt == limit - 1'b1);

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < limit));

    // R6
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0));

endmodule

// File: rtl/por_io_window.sv
// Saturating timer that measures how long the block has been in user mode.
// The I/O-rail watch window is open while armed and the count is below WIN.
// Assumes: run drops whenever user mode is left, which restarts the count.
module por_io_window #(
    parameter int WIN = 900,
    localparam int WW = $clog2(WIN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic arm,
    output logic open
);

    localparam logic [WW-1:0] WIN_L = WW'(WIN);

    logic [WW-1:0] cnt;

    // Count the cycles spent in user mode, stopping at WIN.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (cnt != WIN_L)
            cnt <= cnt + 1'b1;
    end

    // The window is open only in instant-on user mode, before the limit.
    always_comb open = arm && run && (cnt < WIN_L);

    // R10
    win_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= WIN_L);

endmodule

// File: rtl/por_sequencer.sv
// Multi-rail power-on reset sequencer. It synchronizes the per-rail good
// flags, holds the main reset until every rail is good, runs a
// mode-selected delay, then watches for brown-out. A core or analog drop
// always resets. An I/O drop resets only inside the instant-on window.
// Assumes: STD_DLY and FAST_DLY are at least 1, and IO_WIN is at least 1.
module por_sequencer
    import por_seq_pkg::*;
#(
    parameter int N_IO     = 2,
    parameter int STD_DLY  = 200,
    parameter int FAST_DLY = 40,
    parameter int IO_WIN   = 900
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            core_ok,
    input  logic            analog_ok,
    input  logic [N_IO-1:0] io_ok,
    input  logic [1:0]      delay_mode,
    output logic            main_rst,
    output logic            user_mode
);

    localparam int NR   = N_IO + 2;
    localparam int DMAX = (STD_DLY > FAST_DLY) ? STD_DLY : FAST_DLY;
    localparam int CW   = $clog2(DMAX + 1);

    logic [NR-1:0]   raw_flags, syn_flags;
    logic            core_s, ana_s, io_all_s, all_good;
    por_state_t      state, state_nxt;
    dly_mode_t       sel_q, mode_in;
    logic [CW-1:0]   limit;
    logic            tmr_done, win_open;

    assign raw_flags = {io_ok, analog_ok, core_ok};

    por_rail_sync #(.W(NR)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_flags),
        .q     (syn_flags)
    );

    // Split the synchronized flags and combine the per-rail detectors.
    always_comb begin
        core_s   = syn_flags[0];
        ana_s    = syn_flags[1];
        io_all_s = &syn_flags[NR-1:2];
        all_good = core_s && ana_s && io_all_s;
    end

    // Map the mode input, folding the spare code onto the standard delay.
    always_comb begin
        mode_in = dly_mode_t'(delay_mode);
        if (mode_in == DM_STD_ALT)
            mode_in = DM_STD;
    end

    // Latch the delay mode when the hold state sees every rail good.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= DM_STD;
        else if (state == ST_HOLD && all_good)
            sel_q <= mode_in;
    end

    // Pick the countdown length from the latched mode.
    always_comb limit = (sel_q == DM_FAST) ? CW'(FAST_DLY) : CW'(STD_DLY);

    por_delay_timer #(.CW(CW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state != ST_COUNT),
        .run   (state == ST_COUNT && all_good),
        .limit (limit),
        .done  (tmr_done)
    );

    por_io_window #(.WIN(IO_WIN)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_USER),
        .arm   (sel_q == DM_INSTANT),
        .open  (win_open)
    );

    // Sequencing decisions: hold, count, user mode and brown-out return.
    always_comb begin
        state_nxt = state;
        case (state)
            ST_HOLD:
                if (all_good)
                    state_nxt = (mode_in == DM_INSTANT) ? ST_USER : ST_COUNT;
            ST_COUNT:
                if (!all_good)
                    state_nxt = ST_HOLD;
                else if (tmr_done)
                    state_nxt = ST_USER;
            ST_USER:
                if (!core_s || !ana_s)
                    state_nxt = ST_HOLD;
                else if (!io_all_s && win_open)
                    state_nxt = ST_HOLD;
            default:
                state_nxt = ST_HOLD;
        endcase
    end

    // State register plus the two registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_HOLD;
            main_rst  <= 1'b1;
            user_mode <= 1'b0;
        end else begin
            state     <= state_nxt;
            main_rst  <= (state_nxt != ST_USER);
            user_mode <= (state_nxt == ST_USER);
        end
    end

    // R11
    out_cmpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        main_rst ^ user_mode);

    // R2
    release_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(main_rst) |-> $past(all_good));

    // R7
    brownout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_USER && (!core_s || !ana_s)) |=> main_rst);

    // R6
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && !all_good) |=> (state == ST_HOLD));

    // R8
    io_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_USER && core_s && ana_s && !win_open) |=> !main_rst);

endmodule

// File: tb/sim_por_sequencer.sv
module sim_por_sequencer;

    localparam int N_IO     = 2;
    localparam int STD_DLY  = 200;
    localparam int FAST_DLY = 40;
    localparam int IO_WIN   = 900;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            core_ok, analog_ok;
    logic [N_IO-1:0] io_ok;
    logic [1:0]      delay_mode;
    logic            main_rst, user_mode;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    por_sequencer #(
        .N_IO(N_IO), .STD_DLY(STD_DLY), .FAST_DLY(FAST_DLY), .IO_WIN(IO_WIN)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .core_ok(core_ok), .analog_ok(analog_ok),
        .io_ok(io_ok), .delay_mode(delay_mode),
        .main_rst(main_rst), .user_mode(user_mode)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Count rising edges until main_rst equals target; optionally switch mode.
    task automatic measure(input logic target, input int sw_at,
                           input logic [1:0] sw_mode, output int n);
        n = 0;
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (main_rst == target) break;
            if (n == sw_at) delay_mode = sw_mode;
        end
    endtask

    task automatic go_hold();
        @(negedge clk);
        core_ok = 0; analog_ok = 0; io_ok = '0;
        cycles(6);
    endtask

    task automatic release_with(input logic [1:0] m, input string req, input int exp);
        int n;
        go_hold();
        delay_mode = m;
        core_ok = 1; analog_ok = 1; io_ok = '1;
        measure(1'b0, -1, 2'b00, n);
        chk(req, n, exp);
        chk({req, " user_mode"}, user_mode, 1);
    endtask

    task automatic t_reset();
        rst_n = 0; core_ok = 1; analog_ok = 1; io_ok = '1; delay_mode = 2'b10;
        cycles(4);
        chk("R1 main_rst", main_rst, 1);
        chk("R1 user_mode", user_mode, 0);
        rst_n = 1;
        cycles(1);
    endtask

    task automatic t_partial();  // R2
        int n;
        go_hold();
        delay_mode = 2'b10;
        core_ok = 1; analog_ok = 1; io_ok = 2'b01;
        cycles(50);
        chk("R2 one io rail low", main_rst, 1);
        io_ok = 2'b11; analog_ok = 0;
        cycles(50);
        chk("R2 analog low", main_rst, 1);
        analog_ok = 1;
        measure(1'b0, -1, 2'b00, n);
        chk("R2 last rail latency", n, 3);
    endtask

    task automatic t_restart();  // R6
        int n;
        go_hold();
        delay_mode = 2'b01;
        core_ok = 1; analog_ok = 1; io_ok = '1;
        cycles(20);
        io_ok[0] = 0;
        cycles(5);
        chk("R6 still held", main_rst, 1);
        io_ok[0] = 1;
        measure(1'b0, -1, 2'b00, n);
        chk("R6 restart latency", n, 3 + FAST_DLY);
    endtask

    task automatic t_brownout(input bit use_core);  // R7
        int n;
        release_with(2'b01, "R7 setup", 3 + FAST_DLY);
        cycles(30);
        if (use_core) core_ok = 0; else analog_ok = 0;
        measure(1'b1, -1, 2'b00, n);
        chk(use_core ? "R7 core drop" : "R7 analog drop", n, 3);
        chk("R7 user_mode low", user_mode, 0);
        if (use_core) core_ok = 1; else analog_ok = 1;
        measure(1'b0, -1, 2'b00, n);
        chk("R7 re-release", n, 3 + FAST_DLY);
    endtask

    task automatic t_io_delayed();  // R8
        release_with(2'b00, "R8 setup", 3 + STD_DLY);
        cycles(10);
        io_ok[1] = 0;
        cycles(40);
        chk("R8 io drop ignored main_rst", main_rst, 0);
        chk("R8 io drop ignored user_mode", user_mode, 1);
        io_ok[1] = 1;
    endtask

    task automatic t_io_window_in();  // R9
        int n;
        release_with(2'b10, "R9 setup", 3);
        cycles(100);
        io_ok[1] = 0;
        measure(1'b1, -1, 2'b00, n);
        chk("R9 io drop in window", n, 3);
        io_ok[1] = 1;
    endtask

    task automatic t_io_window_out();  // R10
        release_with(2'b10, "R10 setup", 3);
        cycles(IO_WIN + 20);
        io_ok[0] = 0;
        cycles(40);
        chk("R10 io drop after window", main_rst, 0);
        chk("R10 user_mode", user_mode, 1);
        io_ok[0] = 1;
    endtask

    task automatic t_mode_frozen();  // R12
        int n;
        go_hold();
        delay_mode = 2'b00;
        core_ok = 1; analog_ok = 1; io_ok = '1;
        measure(1'b0, 10, 2'b10, n);
        chk("R12 mode change ignored", n, 3 + STD_DLY);
    endtask

    task automatic t_complement();  // R11
        for (int i = 0; i < 20; i++) begin
            chk("R11 outputs complementary", int'(main_rst ^ user_mode), 1);
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (finished) disable watchdog;
        end
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        release_with(2'b00, "R3 standard", 3 + STD_DLY);
        release_with(2'b11, "R3 spare code", 3 + STD_DLY);
        release_with(2'b01, "R4 fast", 3 + FAST_DLY);
        release_with(2'b10, "R5 instant", 3);
        t_complement();
        t_partial();
        t_restart();
        t_brownout(1'b1);
        t_brownout(1'b0);
        t_io_delayed();
        t_io_window_in();
        t_io_window_out();
        t_mode_frozen();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule